// File: doc/BRIEF.md
# Pixel Word Unpacker and Colour Formatter

This block sits between a display fetch FIFO and a 24-bit panel data bus. It accepts 32-bit words through a valid/ready handshake. The byte order of each word can be rearranged. Each word is then split into pixels of 1, 2, 4, 8, 16 or 24 bits, and one pixel is emitted per pixel-clock enable as a 24-bit RGB value with a valid strobe.

Pixels of 8 bits or fewer index a 256-entry, 16-bit colour table. Software fills the table through a write port. 16-bit pixels are expanded directly in one of two packings. 24-bit pixels are taken from either the low or the high three bytes of the word. An optional final inversion flips every output bit.

When the enable arrives and no word is held, the block repeats nothing and counts the missed slot.

Top module: `pix_unpack_top`

## Requirements
- R1: The depth field `mode` selects the pixel size: 4'b1000 = 1, 4'b1001 = 2, 4'b1010 = 4, 4'b1011 = 8, 4'b1100 = 16 and 4'b1101 = 24 bits per pixel. A word holds 32, 16, 8, 4, 2 or 1 pixels. Pixels leave the most significant end of the (swapped) word first.
- R2: A new word is accepted only when no word is held, or in the same cycle that the held word's last pixel is emitted. `word_ready` is low while earlier pixels remain.
- R3: In the 1, 2, 4 and 8 bit modes, the pixel value (zero-extended) addresses the colour table. Entry p[15:0] is output as 5:6:5 as follows: R = {p[15:11], p[15:13]}, G = {p[10:5], p[10:9]}, B = {p[4:0], p[4:2]}. The output is `vid_data` = {R, G, B}.
- R4: In 16-bit mode with `fmt565` = 1, the pixel bypasses the table and expands with the same 5:6:5 rule as R3.
- R5: In 16-bit mode with `fmt565` = 0, the pixel is read as r = p[15:11], g = p[10:6], b = p[5:1] and i = p[0]. Each component becomes {c5, i, c5[4:3]}.
- R6: In 24-bit mode, `rgb_hi` = 0 outputs word[23:0] and `rgb_hi` = 1 outputs word[31:8].
- R7: `swap_bytes` = 1 reverses the four bytes of an incoming word before unpacking.
- R8: `swap_halves` = 1 exchanges the two 16-bit halves of an incoming word. This is applied after any byte reversal.
- R9: `invert` = 1 complements all 24 output bits after formatting.
- R10: When `pix_en` is high and no word is held, `vid_valid` stays low, `vid_data` keeps its last value, and `underrun_cnt` increments by one.
- R11: After reset, `vid_data` = 0, `vid_valid` = 0, `underrun_cnt` = 0 and `word_ready` = 1.
- R12: A pixel is emitted only in a cycle with `pix_en` high, at most one per enable. The registered output appears one clock after that enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Input word available |
| word_data | input | 32 | Input word |
| word_ready | output | 1 | Word accepted this cycle when valid |
| pix_en | input | 1 | Pixel clock enable |
| mode | input | 4 | Depth code |
| swap_bytes | input | 1 | Reverse byte order |
| swap_halves | input | 1 | Exchange half-words |
| fmt565 | input | 1 | 16-bit packing select |
| rgb_hi | input | 1 | 24-bit field select |
| invert | input | 1 | Output inversion |
| pal_we | input | 1 | Colour table write strobe |
| pal_waddr | input | 8 | Colour table write index |
| pal_wdata | input | 16 | Colour table write value |
| vid_data | output | 24 | Pixel output |
| vid_valid | output | 1 | Pixel output strobe |
| underrun_cnt | output | 16 | Missed-slot count |

## Verification
The assertions assume `mode` carries one of the six legal depth codes whenever a word is held. They also assume that `mode`, `fmt565`, `rgb_hi` and `invert` do not change while a word is partly emitted. The stimulus changes these controls only on a falling edge, and only after the previous word has fully drained. Colour table writes are done with `pix_en` low before any palettized word arrives, so no lookup sees an entry in the middle of an update.

// File: rtl/pu_pkg.sv
`timescale 1ns/1ps
package pu_pkg;
    localparam int WORD_W = 32;
    localparam int VD_W   = 24;
    localparam int CLR_W  = 16;

    localparam logic [3:0] DEPTH_1  = 4'b1000;
    localparam logic [3:0] DEPTH_2  = 4'b1001;
    localparam logic [3:0] DEPTH_4  = 4'b1010;
    localparam logic [3:0] DEPTH_8  = 4'b1011;
    localparam logic [3:0] DEPTH_16 = 4'b1100;
    localparam logic [3:0] DEPTH_24 = 4'b1101;

    function automatic logic [5:0] depth_bits(input logic [3:0] m);
        case (m)
            DEPTH_1:  return 6'd1;
            DEPTH_2:  return 6'd2;
            DEPTH_4:  return 6'd4;
            DEPTH_16: return 6'd16;
            DEPTH_24: return 6'd24;
            default:  return 6'd8;
        endcase
    endfunction

    function automatic logic [5:0] depth_count(input logic [3:0] m);
        case (m)
            DEPTH_1:  return 6'd32;
            DEPTH_2:  return 6'd16;
            DEPTH_4:  return 6'd8;
            DEPTH_16: return 6'd2;
            DEPTH_24: return 6'd1;
            default:  return 6'd4;
        endcase
    endfunction

    function automatic logic depth_legal(input logic [3:0] m);
        return m[3] && (m[2:0] <= 3'd5);
    endfunction
endpackage

// File: rtl/pu_swap.sv
`timescale 1ns/1ps
module pu_swap #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         rev_bytes,
    input  logic         xchg_halves,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;
    logic [W-1:0] reversed;
    logic [W-1:0] stage1;

    for (genvar b = 0; b < NB; b++) begin : g_rev
        assign reversed[8*b +: 8] = din[W-8-8*b +: 8];
    end

    assign stage1 = rev_bytes ? reversed : din;
    assign dout   = xchg_halves ? {stage1[W/2-1:0], stage1[W-1:W/2]} : stage1;
endmodule

// File: rtl/pu_palette.sv
`timescale 1ns/1ps
module pu_palette #(
    parameter int ENTRIES = 256,
    parameter int DW      = 16
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [$clog2(ENTRIES)-1:0] raddr,
    output logic [DW-1:0]              rdata
);
    logic [DW-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pu_expand.sv
`timescale 1ns/1ps
module pu_expand (
    input  logic [15:0] pix,
    input  logic        is565,
    output logic [23:0] rgb
);
    logic [4:0] r5, b5, g5;
    logic [5:0] g6;
    logic       ib;

    always_comb begin
        r5 = pix[15:11];
        g6 = pix[10:5];
        b5 = pix[4:0];
        g5 = pix[10:6];
        ib = pix[0];
        if (is565) begin
            rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
        end else begin
            rgb = {r5, ib, r5[4:3], g5, ib, g5[4:3], pix[5:1], ib, pix[5:4]};
        end
    end
endmodule

// File: rtl/pix_unpack_top.sv
`timescale 1ns/1ps
module pix_unpack_top #(
    parameter int CNT_W       = 16,
    parameter int PAL_ENTRIES = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           word_valid,
    input  logic [31:0]                    word_data,
    output logic                           word_ready,
    input  logic                           pix_en,
    input  logic [3:0]                     mode,
    input  logic                           swap_bytes,
    input  logic                           swap_halves,
    input  logic                           fmt565,
    input  logic                           rgb_hi,
    input  logic                           invert,
    input  logic                           pal_we,
    input  logic [$clog2(PAL_ENTRIES)-1:0] pal_waddr,
    input  logic [15:0]                    pal_wdata,
    output logic [23:0]                    vid_data,
    output logic                           vid_valid,
    output logic [CNT_W-1:0]               underrun_cnt
);
    import pu_pkg::*;

    localparam int PAL_AW = $clog2(PAL_ENTRIES);
    localparam int IDX_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              have;
        logic [IDX_W-1:0]  idx;
        logic [VD_W-1:0]   vd;
        logic              vld;
        logic [CNT_W-1:0]  urun;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] swapped_w;
    logic [5:0]        nbits;
    logic [5:0]        npix;
    logic              last_pix;
    logic [WORD_W-1:0] field;
    logic [WORD_W-1:0] fmask;
    int                shamt;
    logic              is_pal;
    logic [PAL_AW-1:0] pal_ra;
    logic [CLR_W-1:0]  pal_rd;
    logic [CLR_W-1:0]  raw16;
    logic              use565;
    logic [VD_W-1:0]   expanded;
    logic [VD_W-1:0]   rgb_pix;
    logic [VD_W-1:0]   out_pix;

    pu_swap #(.W(WORD_W)) u_swap (
        .din         (word_data),
        .rev_bytes   (swap_bytes),
        .xchg_halves (swap_halves),
        .dout        (swapped_w)
    );

    pu_palette #(.ENTRIES(PAL_ENTRIES), .DW(CLR_W)) u_pal (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .raddr (pal_ra),
        .rdata (pal_rd)
    );

    pu_expand u_exp (
        .pix   (raw16),
        .is565 (use565),
        .rgb   (expanded)
    );

    always_comb begin
        nbits    = depth_bits(mode);
        npix     = depth_count(mode);
        last_pix = st_q.have && ({1'b0, st_q.idx} == npix - 6'd1);
        shamt    = WORD_W - int'(nbits) * (int'(st_q.idx) + 1);
        if (shamt < 0) shamt = 0;
        fmask    = (nbits >= 6'd32) ? '1 : ((WORD_W'(1) << nbits) - WORD_W'(1));
        field    = (st_q.word >> shamt) & fmask;
        is_pal   = (nbits <= 6'd8);
        pal_ra   = field[PAL_AW-1:0];
        raw16    = is_pal ? pal_rd : field[CLR_W-1:0];
        use565   = is_pal ? 1'b1 : fmt565;
        if (mode == DEPTH_24) begin
            rgb_pix = rgb_hi ? st_q.word[WORD_W-1:WORD_W-VD_W] : st_q.word[VD_W-1:0];
        end else begin
            rgb_pix = expanded;
        end
        out_pix = invert ? ~rgb_pix : rgb_pix;
    end

    assign word_ready = !st_q.have || (pix_en && last_pix);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (pix_en && st_q.have) begin
            st_d.vd  = out_pix;
            st_d.vld = 1'b1;
            if (last_pix) begin
                st_d.have = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
        if (pix_en && !st_q.have) begin
            st_d.urun = st_q.urun + CNT_W'(1);
        end
        if (word_valid && word_ready) begin
            st_d.word = swapped_w;
            st_d.have = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vid_data     = st_q.vd;
    assign vid_valid    = st_q.vld;
    assign underrun_cnt = st_q.urun;

    // R1: a held word is always interpreted with a legal depth code
    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.have |-> depth_legal(mode));

    // R2: taking a word while one is held means its last pixel left on that edge
    assert_pull_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && st_q.have) |=> (vid_valid && st_q.have && st_q.idx == '0));

    // R10: output word does not move when no pixel is emitted
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_valid |-> $stable(vid_data));

    // R10: every empty enabled slot is counted once
    assert_underrun_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !st_q.have) |=> (underrun_cnt == $past(underrun_cnt) + CNT_W'(1)));

    // R12: a strobe is only produced by an enable
    assert_strobe_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> $past(pix_en));
endmodule

// File: tb/tb_pix_unpack_top.sv
`timescale 1ns/1ps
module tb_pix_unpack_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_ready;
    logic        pix_en;
    logic [3:0]  mode;
    logic        swap_bytes, swap_halves, fmt565, rgb_hi, invert;
    logic        pal_we;
    logic [7:0]  pal_waddr;
    logic [15:0] pal_wdata;
    logic [23:0] vid_data;
    logic        vid_valid;
    logic [15:0] underrun_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] pal_sh [256];

    always #2 clk = ~clk;

    pix_unpack_top dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .pix_en(pix_en), .mode(mode),
        .swap_bytes(swap_bytes), .swap_halves(swap_halves), .fmt565(fmt565),
        .rgb_hi(rgb_hi), .invert(invert), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata), .vid_data(vid_data), .vid_valid(vid_valid),
        .underrun_cnt(underrun_cnt)
    );

    // {mode, swap_bytes, swap_halves, fmt565, rgb_hi, invert, word}
    localparam logic [40:0] VEC [12] = '{
        {4'b1000, 5'b00000, 32'hA5C3_0F81},
        {4'b1001, 5'b00000, 32'h1B6C_93E4},
        {4'b1010, 5'b00000, 32'h0123_4567},
        {4'b1011, 5'b00000, 32'hFE01_7F80},
        {4'b1100, 5'b00100, 32'hF81F_07E0},
        {4'b1100, 5'b00000, 32'h8421_7BDE},
        {4'b1101, 5'b00000, 32'hAA12_3456},
        {4'b1101, 5'b00010, 32'hAA12_3456},
        {4'b1011, 5'b10000, 32'h0102_0304},
        {4'b1011, 5'b01000, 32'h0102_0304},
        {4'b1011, 5'b11000, 32'h0102_0304},
        {4'b1100, 5'b00101, 32'h1234_ABCD}
    };
    localparam string VTAG [12] = '{"R1 R3", "R1 R3", "R1 R3", "R1 R3", "R4", "R5",
                                     "R6", "R6", "R7", "R8", "R7 R8", "R9"};

    function automatic logic [23:0] m565(input logic [15:0] p);
        return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
    endfunction

    function automatic logic [23:0] m5551(input logic [15:0] p);
        return {p[15:11], p[0], p[15:14], p[10:6], p[0], p[10:9], p[5:1], p[0], p[5:4]};
    endfunction

    function automatic int bits_for(input logic [3:0] m);
        case (m)
            4'b1000: return 1;
            4'b1001: return 2;
            4'b1010: return 4;
            4'b1011: return 8;
            4'b1100: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] model(input logic [40:0] v, input int k);
        logic [31:0] w, f;
        logic [23:0] r;
        int b;
        w = v[31:0];
        if (v[36]) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
        if (v[35]) w = {w[15:0], w[31:16]};
        b = bits_for(v[40:37]);
        if (b == 24) begin
            r = v[33] ? w[31:8] : w[23:0];
        end else begin
            f = (w >> (32 - b * (k + 1))) & ((b == 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 1));
            if (b <= 8)      r = m565(pal_sh[f[7:0]]);
            else if (v[34])  r = m565(f[15:0]);
            else             r = m5551(f[15:0]);
        end
        return v[32] ? ~r : r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [40:0] v);
        mode        = v[40:37];
        swap_bytes  = v[36];
        swap_halves = v[35];
        fmt565      = v[34];
        rgb_hi      = v[33];
        invert      = v[32];
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; word_valid = 1'b0; word_data = '0; pix_en = 1'b0;
        mode = 4'b1011; swap_bytes = 0; swap_halves = 0; fmt565 = 0; rgb_hi = 0; invert = 0;
        pal_we = 1'b0; pal_waddr = '0; pal_wdata = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(vid_data == 24'h0, "R11", 32'(vid_data), 0);
        check(vid_valid == 1'b0, "R11", 32'(vid_valid), 0);
        check(underrun_cnt == 16'h0, "R11", 32'(underrun_cnt), 0);
        check(word_ready == 1'b1, "R11", 32'(word_ready), 1);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) begin
            pal_sh[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
            @(negedge clk);
            pal_we = 1'b1; pal_waddr = 8'(i); pal_wdata = pal_sh[i];
        end
        @(negedge clk);
        pal_we = 1'b0;

        // table walk
        for (int v = 0; v < 12; v++) begin
            int n;
            n = 32 / bits_for(VEC[v][40:37]);
            if (bits_for(VEC[v][40:37]) == 24) n = 1;
            @(negedge clk);
            set_ctl(VEC[v]);
            pix_en = 1'b1;
            word_valid = 1'b1;
            word_data = VEC[v][31:0];
            @(negedge clk);
            word_valid = 1'b0;
            for (int k = 0; k < n; k++) begin
                @(negedge clk);
                check(vid_valid == 1'b1, {VTAG[v], " R12"}, 32'(vid_valid), 1);
                check(vid_data == model(VEC[v], k), VTAG[v], 32'(vid_data),
                      32'(model(VEC[v], k)));
                if (k < n - 2) check(word_ready == 1'b0, "R2", 32'(word_ready), 0);
                if (k == n - 2) check(word_ready == 1'b1, "R2", 32'(word_ready), 1);
            end
        end

        // R12 and R2: word held while the enable is low
        begin
            logic [15:0] c0;
            logic [40:0] dv;
            logic [23:0] held;
            dv = {4'b1011, 5'b00000, 32'h11FF_2280};
            @(negedge clk);
            set_ctl(dv);
            pix_en = 1'b0;
            word_valid = 1'b1;
            word_data = dv[31:0];
            @(negedge clk);
            word_valid = 1'b0;
            c0 = underrun_cnt;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(vid_valid == 1'b0, "R12", 32'(vid_valid), 0);
                check(word_ready == 1'b0, "R2", 32'(word_ready), 0);
                check(underrun_cnt == c0, "R12", 32'(underrun_cnt), 32'(c0));
            end
            pix_en = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check(vid_valid == 1'b1 && vid_data == model(dv, k), "R12 R3",
                      32'(vid_data), 32'(model(dv, k)));
            end
            // R10: empty input with the enable high
            c0 = underrun_cnt;
            held = vid_data;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check(vid_valid == 1'b0, "R10", 32'(vid_valid), 0);
                check(vid_data == held, "R10", 32'(vid_data), 32'(held));
            end
            check(underrun_cnt == c0 + 16'd5, "R10", 32'(underrun_cnt), 32'(c0 + 16'd5));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule